// File: doc/BRIEF.md
# Serial GPIO Expander Controller

This block multiplies the number of general-purpose pins a chip can offer. It drives a chain of external shift registers over four wires: a serial clock, a data-out line, a data-in line and a load strobe. It keeps two banks of 32 ports, with up to 4 bits per port. The output bank is streamed out and the input bank is captured back, both within the same frame. Frames repeat without pause. Each frame walks the enabled ports in ascending order and then closes with a load strobe, which makes the external registers latch the outputs and snapshot their inputs.

Software sets the port mask, the bits per port and the serial clock divider through a small word-addressed register port. The port mask can be written whole or built up one inclusive range at a time. Software also writes the output bank, reads the input snapshot, and manages one interrupt enable and one sticky status bit per input. The interrupt line is active high and stays asserted while any enabled status bit is set.

Top module: `serial_gpio_expander`

## Requirements
- R1: While reset is held, ser_load is 1, ser_clk is 0, ser_dout is 0 and irq is 0, and the input bank reads as zero.
- R2: A frame visits the enabled ports in ascending port order. Within each port it sends bit indices 0 up to the configured maximum, one bit per serial clock period. During the bit for port p, bit index b, ser_dout carries bit p of output word b.
- R3: ser_dout changes only while ser_clk is low. ser_din is sampled at the rising edge of ser_clk.
- R4: Each frame ends with a load slot that lasts exactly one serial clock period. During the load slot ser_load is 1, and ser_clk and ser_dout are 0. With an empty port mask, frames consist of load slots only, so ser_load stays high and ser_clk stays low.
- R5: One serial clock period lasts D system clocks. D is the divider value rounded down to an even number. Divider values 0 and 1 give D = 2.
- R6: Writing the range register (address 0x03, low bound in bits [4:0], high bound in bits [12:8]) ORs ports low through high, inclusive, into the requested mask. A write with low greater than high leaves the mask unchanged.
- R7: New values of the mask, the bits-per-port code and the divider read back at once, but they take effect only at the end of the next load slot. A frame already in progress keeps its old length.
- R8: The input bank changes only when a load slot ends. It then holds the bits captured in the frame just finished. Ports that are not enabled, and bit indices above the configured maximum, read as 0.
- R9: When a load slot ends, each status bit whose interrupt enable is set and whose captured input is 1 becomes set. Writing 1 to a status bit clears it. irq is the OR over all status bits that are both set and enabled.
- R10: The register map is as follows. 0x00 holds the bits-per-port code in bits [1:0]; the code is the number of bits per port minus 1. 0x01 holds the divider in bits [15:0]. 0x02 holds the requested port mask, bit p for port p. 0x08+b is output word b. 0x0C+b is input word b, read-only. 0x10+b is enable word b. 0x14+b is status word b. In every bank word, bit p belongs to port p. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ser_clk | output | 1 | Serial clock to the shift register chain |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data from the chain |
| ser_load | output | 1 | End-of-frame load strobe |
| irq | output | 1 | Level-high interrupt |

## Verification
The assertions assume that reg_we, reg_addr and ser_din are never unknown, and that reset is applied at start-up. The interrupt checks additionally assume that software never re-enables an input whose stale status bit is still set in the middle of a frame. The bench changes every input only on the falling system clock edge. It holds ser_din at 0 outside the frames it observes, so unobserved frames can only capture zeros. It writes the enables only while the inputs it watches are zero. Configuration changes in the middle of a frame are made deliberately, to exercise the frame-boundary rule.

// File: rtl/serial_gpio_expander.sv
module serial_gpio_expander #(
  parameter int NPORT   = 32,
  parameter int NBIT    = 4,
  parameter int DIVW    = 16,
  parameter int DIV_RST = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        ser_clk,
  output logic        ser_dout,
  input  logic        ser_din,
  output logic        ser_load,
  output logic        irq
);
  localparam int PW = $clog2(NPORT);
  localparam int BW = (NBIT > 1) ? $clog2(NBIT) : 1;

  logic [NBIT-1:0][NPORT-1:0] out_q, in_q, shd_q, ie_q, st_q, st_clr, st_set;
  logic [NPORT-1:0] mask_req, mask_act;
  logic [BW-1:0]    bits_req, bits_act, cur_bit;
  logic [DIVW-1:0]  div_req, div_act, phase, half;
  logic [PW-1:0]    cur_port;
  logic             in_load, dout_q;

  function automatic logic [DIVW-1:0] clamp_div(input logic [DIVW-1:0] d);
    return (d < DIVW'(2)) ? DIVW'(2) : {d[DIVW-1:1], 1'b0};
  endfunction

  function automatic logic [PW:0] next_port(input logic [NPORT-1:0] m, input logic [PW:0] from);
    logic [PW:0] r;
    r = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (m[i] && i >= int'(from)) r = {1'b1, PW'(i)};
    return r;
  endfunction

  function automatic logic [NPORT-1:0] span(input logic [4:0] lo, input logic [4:0] hi);
    logic [NPORT-1:0] r;
    r = '0;
    for (int i = 0; i < NPORT; i++)
      if (i >= int'(lo) && i <= int'(hi)) r[i] = 1'b1;
    return r;
  endfunction

  wire [1:0]  widx     = reg_addr[1:0];
  wire        widx_ok  = int'(widx) < NBIT;
  wire        slot_end = (phase == div_act - 1'b1);
  wire        bit_more = (cur_bit != bits_act);
  wire [PW:0] nx_run   = next_port(mask_act, {1'b0, cur_port} + 1'b1);
  wire [PW:0] nx_new   = next_port(mask_req, '0);

  assign half     = div_act >> 1;
  assign ser_clk  = !in_load && (phase >= half);
  assign ser_load = in_load;
  assign ser_dout = dout_q;
  assign irq      = |(st_q & ie_q);

  always_comb begin
    st_clr = '0;
    if (reg_we && reg_addr[5:2] == 4'd5 && widx_ok) st_clr[widx] = reg_wdata[NPORT-1:0];
    st_set = (in_load && slot_end) ? (shd_q & ie_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_req <= '0;
      bits_req <= '0;
      div_req  <= DIVW'(DIV_RST);
      out_q    <= '0;
      ie_q     <= '0;
    end else if (reg_we) begin
      case (reg_addr[5:2])
        4'd0: case (widx)
          2'd0:    bits_req <= reg_wdata[BW-1:0];
          2'd1:    div_req  <= reg_wdata[DIVW-1:0];
          2'd2:    mask_req <= reg_wdata[NPORT-1:0];
          default: mask_req <= mask_req | span(reg_wdata[4:0], reg_wdata[12:8]);
        endcase
        4'd2: if (widx_ok) out_q[widx] <= reg_wdata[NPORT-1:0];
        4'd4: if (widx_ok) ie_q[widx]  <= reg_wdata[NPORT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_load  <= 1'b1;
      phase    <= '0;
      cur_port <= '0;
      cur_bit  <= '0;
      dout_q   <= 1'b0;
      mask_act <= '0;
      bits_act <= '0;
      div_act  <= clamp_div(DIVW'(DIV_RST));
      shd_q    <= '0;
      in_q     <= '0;
      st_q     <= '0;
    end else begin
      phase <= slot_end ? '0 : phase + 1'b1;
      st_q  <= (st_q & ~st_clr) | st_set;
      if (!in_load && phase == half - 1'b1) shd_q[cur_bit][cur_port] <= ser_din;
      if (slot_end) begin
        if (in_load) begin
          in_q     <= shd_q;
          shd_q    <= '0;
          mask_act <= mask_req;
          bits_act <= bits_req;
          div_act  <= clamp_div(div_req);
          if (nx_new[PW]) begin
            in_load  <= 1'b0;
            cur_port <= nx_new[PW-1:0];
            cur_bit  <= '0;
            dout_q   <= out_q[0][nx_new[PW-1:0]];
          end
        end else if (bit_more) begin
          cur_bit <= cur_bit + 1'b1;
          dout_q  <= out_q[cur_bit + 1'b1][cur_port];
        end else if (nx_run[PW]) begin
          cur_port <= nx_run[PW-1:0];
          cur_bit  <= '0;
          dout_q   <= out_q[0][nx_run[PW-1:0]];
        end else begin
          in_load <= 1'b1;
          dout_q  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[5:2])
      4'd0: case (widx)
        2'd0:    reg_rdata = 32'(bits_req);
        2'd1:    reg_rdata = 32'(div_req);
        2'd2:    reg_rdata = 32'(mask_req);
        default: ;
      endcase
      4'd2: if (widx_ok) reg_rdata = 32'(out_q[widx]);
      4'd3: if (widx_ok) reg_rdata = 32'(in_q[widx]);
      4'd4: if (widx_ok) reg_rdata = 32'(ie_q[widx]);
      4'd5: if (widx_ok) reg_rdata = 32'(st_q[widx]);
      default: ;
    endcase
  end
endmodule

// File: rtl/serial_gpio_expander_chk.sv
module serial_gpio_expander_chk #(
  parameter int NPORT = 32,
  parameter int NBIT  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ser_clk,
  input logic                  ser_dout,
  input logic                  ser_load,
  input logic [NBIT*NPORT-1:0] in_bank,
  input logic [NPORT-1:0]      mask_act
);
  AST_LOAD_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) ser_load |-> !ser_clk); // R4
  AST_LOAD_DOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n) ser_load |-> !ser_dout); // R4
  AST_DOUT_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (ser_clk && $past(ser_clk)) |-> $stable(ser_dout)); // R3
  AST_INBANK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !$past(ser_load) |-> $stable(in_bank)); // R8
  AST_MASK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !$past(ser_load) |-> $stable(mask_act)); // R7
endmodule

bind serial_gpio_expander serial_gpio_expander_chk #(.NPORT(NPORT), .NBIT(NBIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dout(ser_dout),
  .ser_load(ser_load), .in_bank(in_q), .mask_act(mask_act));

// File: tb/test_serial_gpio_expander.sv
module test_serial_gpio_expander;
  logic clk = 0, rst_n = 0, reg_we = 0, ser_din = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ser_clk, ser_dout, ser_load, irq;
  int checks = 0, errors = 0;
  logic [3:0][31:0] m_out = '0, m_pat = '0, m_ie = '0, m_st = '0;
  logic [31:0] m_mask = 0;
  int m_bits = 0, m_div = 20;

  always #4 clk = ~clk;

  serial_gpio_expander i_serial_gpio_expander (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din),
    .ser_load(ser_load), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d < 2) ? 2 : (d & ~1);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_cfg(input logic [31:0] mask, input int bits, input int div);
    wr(6'h02, mask); wr(6'h00, 32'(bits)); wr(6'h01, 32'(div));
    m_mask = mask; m_bits = bits; m_div = div;
  endtask

  // Observe one frame with the active model config; optionally rewrite the mask at its start.
  task automatic frame_run(input bit chg, input logic [31:0] chg_mask);
    int np[128]; int nb[128]; int n = 0; int k = 0; int t = 0; int t0 = 0; int per = 0;
    int bad = 0; int w = 0; logic pl, ps;
    for (int p = 0; p < 32; p++)
      if (m_mask[p]) for (int b = 0; b <= m_bits; b++) begin np[n] = p; nb[n] = b; n++; end
    pl = ser_load;
    forever begin @(negedge clk); if (pl && !ser_load) break; pl = ser_load; end
    if (chg) begin reg_we = 1; reg_addr = 6'h02; reg_wdata = chg_mask; end
    ps = 0;
    while (!ser_load) begin
      ser_din = (k < n) ? m_pat[nb[k]][np[k]] : 1'b0;
      @(negedge clk); t++;
      reg_we = 0;
      if (!ps && ser_clk) begin
        if (k >= n || ser_dout !== m_out[nb[k]][np[k]]) bad++;
        if (k == 0) t0 = t;
        if (k == 1) per = t - t0;
        k++;
      end
      ps = ser_clk;
    end
    ser_din = 0;
    check("R2 bit count", 32'(k), 32'(n));
    check("R2 dout order", 32'(bad), 0);
    if (n >= 2) check("R5 clock period", 32'(per), 32'(eff_div(m_div)));
    while (ser_load) begin w++; @(negedge clk); end
    check("R4 load width", 32'(w), 32'(eff_div(m_div)));
  endtask

  task automatic check_inputs;
    logic [31:0] d, e;
    for (int b = 0; b < 4; b++) begin
      e = (b <= m_bits) ? (m_pat[b] & m_mask) : 32'h0;
      m_st[b] = m_st[b] | (e & m_ie[b]);
      rd(6'(8'h0C + b), d); check("R8 input word", d, e);
      rd(6'(8'h14 + b), d); check("R9 status word", d, m_st[b]);
    end
    #1; check("R9 irq", 32'(irq), 32'(|(m_st & m_ie)));
  endtask

  task automatic load_all;
    for (int b = 0; b < 4; b++) begin
      wr(6'(8'h08 + b), m_out[b]);
      wr(6'(8'h10 + b), m_ie[b]);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, mk;
    int lo, hi, streak, clkhi;
    void'($urandom(32'h51A7));
    repeat (3) @(negedge clk);
    check("R1 load in reset", 32'(ser_load), 1);
    check("R1 clk in reset", 32'(ser_clk), 0);
    check("R1 dout in reset", 32'(ser_dout), 0);
    check("R1 irq in reset", 32'(irq), 0);
    rd(6'h0C, d); check("R1 input bank reset", d, 0);
    rst_n = 1;

    // R6: ranges into the mask; R10 readback of config words
    wr(6'h02, 0);
    wr(6'h03, 32'h1210); wr(6'h03, 32'h0000); wr(6'h03, 32'h1F1C);
    rd(6'h02, d); check("R6 range mask", d, 32'hF007_0001);
    wr(6'h03, 32'h050A);
    rd(6'h02, d); check("R6 inverted range ignored", d, 32'hF007_0001);
    wr(6'h00, 2); wr(6'h01, 6);
    rd(6'h00, d); check("R10 bits code readback", d, 2);
    rd(6'h01, d); check("R10 divider readback", d, 6);
    rd(6'h3F, d); check("R10 unmapped reads zero", d, 0);
    m_mask = 32'hF007_0001; m_bits = 2; m_div = 6;
    m_out = {32'h8000_0001, 32'h0005_0000, 32'h3000_0001, 32'hA002_0001};
    m_pat = {32'h0, 32'hC001_0000, 32'h2002_0001, 32'h9001_0001};
    load_all;
    frame_run(0, 0); check_inputs;

    // R5: odd and tiny dividers; R2 top port only, all ports full width
    set_cfg(32'h8000_0000, 0, 1);  m_pat[0] = 32'h8000_0000; frame_run(0, 0); check_inputs;
    set_cfg(32'hFFFF_FFFF, 3, 0);  m_pat = {32'hDEAD_BEEF, 32'h1234_5678, 32'h0F0F_F0F0, 32'h5555_AAAA};
    m_out = {32'h0BAD_F00D, 32'hCAFE_1234, 32'h0000_FFFF, 32'hFFFF_0000}; load_all;
    frame_run(0, 0); check_inputs;
    set_cfg(32'h0000_0300, 1, 7); frame_run(0, 0); check_inputs;

    // R7: mask rewrite inside a frame only applies to the following frame
    set_cfg(32'h0000_00F0, 1, 4); m_pat = '0; frame_run(0, 0); check_inputs;
    frame_run(1, 32'h0000_0003);
    rd(6'h02, d); check("R7 mask reads back at once", d, 32'h0000_0003);
    m_mask = 32'h0000_0003; frame_run(0, 0); check_inputs;

    // R9: interrupts raise, stay sticky, clear on write-one
    m_pat = '0; m_ie = '0; m_ie[0] = 32'h0000_0003; load_all;
    m_pat[0] = 32'h0000_0002; frame_run(0, 0); check_inputs;
    m_pat = '0; frame_run(0, 0); check_inputs;
    wr(6'h14, 32'h0000_0002); m_st[0] = m_st[0] & ~32'h0000_0002;
    rd(6'h14, d); check("R9 status cleared", d, m_st[0]);
    #1; check("R9 irq drops after clear", 32'(irq), 0);
    m_ie = '0; load_all; m_st = '0;
    for (int b = 0; b < 4; b++) wr(6'(8'h14 + b), 32'hFFFF_FFFF);

    // Random configurations with ranges
    for (int it = 0; it < 8; it++) begin
      wr(6'h02, 0); mk = 0;
      for (int r = 0; r < 1 + ($urandom % 3); r++) begin
        lo = $urandom % 32; hi = lo + ($urandom % 6); if (hi > 31) hi = 31;
        wr(6'h03, 32'(lo) | (32'(hi) << 8));
        for (int p = lo; p <= hi; p++) mk[p] = 1'b1;
      end
      rd(6'h02, d); check("R6 random ranges", d, mk);
      m_mask = mk; m_bits = $urandom % 4; m_div = $urandom % 7;
      wr(6'h00, 32'(m_bits)); wr(6'h01, 32'(m_div));
      for (int b = 0; b < 4; b++) begin m_out[b] = $urandom; m_pat[b] = $urandom; m_ie[b] = $urandom; end
      load_all;
      frame_run(0, 0); check_inputs;
    end

    // R4: empty mask leaves only load slots
    wr(6'h02, 0);
    streak = 0; clkhi = 0;
    for (int i = 0; i < 3000 && streak < 500; i++) begin
      @(negedge clk);
      if (ser_load) begin streak++; if (ser_clk) clkhi++; end else streak = 0;
    end
    check("R4 empty mask keeps load high", 32'(streak), 500);
    check("R4 no clock with empty mask", 32'(clkhi), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule